// File: doc/BRIEF.md
# Framed PRBS Self-Test Source

This block produces a self-test stream for a four-lane interconnect path. One bit per lane leaves it on every clock. The stream is organised in frames. A frame opens with a preamble of twelve copies of a first alignment byte, then twelve copies of a second alignment byte. The remaining bytes of the frame are filled from a seven-bit pseudorandom sequence. When the frame ends, the next frame starts at once.

The same bit stream feeds every lane, and each lane lags its lower neighbour by one clock. A downstream frame aligner can therefore search any lane and still recover the lane order. A strobe reports when every lane carries generated data. The test-enable input gates the source. An active-low frame reset, shared with the aligner, returns the source to the first bit of a frame.

Top module: `sonet_bist_gen`

## Requirements
- R1: While `rst_n` is low, every bit of `lane_bit` and `lane_valid` read 0. The first enabled clock after release produces the first bit of a frame.
- R2: The first PRE_BYTES bytes of a frame are A1_BYTE (default 8'hF6), and the next PRE_BYTES bytes are A2_BYTE (default 8'h28). Each byte is sent most significant bit first on lane 0.
- R3: Payload bits come from a 7-bit LFSR for x^7+x^6+1. The bit emitted is state bit 6, and the next state is {state[5:0], state[6]^state[5]}. The state resets to SEED (default 7'h7F), so the first payload byte after reset is 8'hFE.
- R4: The LFSR advances only on enabled payload bits. It is not reloaded at a frame boundary, so payload continues from where the previous frame stopped.
- R5: A frame is FRAME_BYTES*8 bits long. The bit after the last one is bit 0 of a new frame, starting with A1_BYTE.
- R6: On every enabled clock, lane k (k >= 1) takes the value that lane k-1 held before that clock.
- R7: `lane_valid` rises once LANES enabled clocks have passed since reset or since `test_en` was last low, and it then stays high while enabled. Lanes not yet reached by the stream read 0.
- R8: A clock with `test_en` low clears every lane and `lane_valid` and holds the frame position and the LFSR. Re-enabling continues the sequence from the held position.
- R9: A reset in the middle of a frame restarts the source at frame bit 0, with the LFSR back at SEED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low asynchronous frame reset |
| test_en | input | 1 | Enables generation; low clears the lanes and holds the position |
| lane_bit | output | LANES | Generated bit per lane; lane k lags lane 0 by k clocks |
| lane_valid | output | 1 | High when every lane carries generated data |

## Verification
The source is first driven with a table of reset, enable and pause segments, long enough to cross several frame boundaries. This separates a correct wrap and LFSR carry-over from a frame counter or LFSR that restarts at each frame. Directed tests then collect whole bytes from lane 0 and compare them with the two alignment bytes and with the first payload byte. This catches bit-order, byte-select and seed or tap errors. Pausing in the middle of the payload, and resetting in the middle of a frame, tell a held position apart from a restarted one. Per-lane comparison on every clock exposes a wrong skew direction or a wrong valid fill count.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  // One step of the x^7 + x^6 + 1 generator; the output bit is state[6].
  function automatic logic [6:0] prbs7_next(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

  // Picks bit 'idx' of a byte where idx 0 is the most significant bit.
  function automatic logic msb_first_bit(input logic [7:0] b, input logic [2:0] idx);
    return b[3'd7 - idx];
  endfunction

endpackage

// File: rtl/sbg_frame_ctr.sv
module sbg_frame_ctr #(
  parameter int FRAME_BYTES = 9720,
  parameter int PRE_BYTES   = 12,
  parameter int POS_W       = $clog2(FRAME_BYTES * 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [POS_W-1:0] pos,
  output logic             in_a2,
  output logic             in_payload,
  output logic             wrap
);
  localparam int FRAME_BITS = FRAME_BYTES * 8;
  localparam int A1_END     = PRE_BYTES * 8;
  localparam int PAY_START  = PRE_BYTES * 16;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  assign wrap       = step && (pos == LAST_POS);
  assign in_payload = (pos >= POS_W'(PAY_START));
  assign in_a2      = (pos >= POS_W'(A1_END)) && !in_payload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (wrap) pos <= '0;
    else if (step) pos <= pos + 1'b1;
  end
endmodule

// File: rtl/sbg_prbs7.sv
module sbg_prbs7 #(
  parameter logic [6:0] SEED = 7'h7F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [6:0] state,
  output logic       bit_o
);
  import sbg_pkg::*;

  assign bit_o = state[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= prbs7_next(state);
  end
endmodule

// File: rtl/sbg_lane_skew.sv
module sbg_lane_skew #(
  parameter int LANES  = 4,
  parameter int FILL_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_bit,
  output logic [LANES-1:0] lanes,
  output logic             valid
);
  logic [FILL_W-1:0] fill;

  for (genvar k = 0; k < LANES; k++) begin : g_stage
    logic src;
    if (k == 0) begin : g_head
      assign src = in_bit;
    end else begin : g_tail
      assign src = lanes[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lanes[k] <= 1'b0;
      else if (!en) lanes[k] <= 1'b0;
      else          lanes[k] <= src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          fill <= '0;
    else if (!en)                        fill <= '0;
    else if (fill != FILL_W'(LANES))     fill <= fill + 1'b1;
  end

  assign valid = (fill == FILL_W'(LANES));
endmodule

// File: rtl/sonet_bist_gen.sv
module sonet_bist_gen #(
  parameter int         LANES       = 4,
  parameter int         FRAME_BYTES = 9720,
  parameter int         PRE_BYTES   = 12,
  parameter logic [7:0] A1_BYTE     = 8'hF6,
  parameter logic [7:0] A2_BYTE     = 8'h28,
  parameter logic [6:0] SEED        = 7'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  output logic [LANES-1:0] lane_bit,
  output logic             lane_valid
);
  import sbg_pkg::*;

  localparam int POS_W = $clog2(FRAME_BYTES * 8);

  // Named internal events, also observed by the bound checker.
  logic [POS_W-1:0] frame_pos;
  logic             in_a2;
  logic             in_payload;
  logic             frame_wrap;
  logic [6:0]       lfsr_q;
  logic             lfsr_bit;
  logic             lfsr_adv;
  logic             gen_bit;

  sbg_frame_ctr #(
    .FRAME_BYTES(FRAME_BYTES),
    .PRE_BYTES  (PRE_BYTES),
    .POS_W      (POS_W)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (test_en),
    .pos       (frame_pos),
    .in_a2     (in_a2),
    .in_payload(in_payload),
    .wrap      (frame_wrap)
  );

  assign lfsr_adv = test_en && in_payload;

  sbg_prbs7 #(.SEED(SEED)) u_prbs (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (lfsr_adv),
    .state(lfsr_q),
    .bit_o(lfsr_bit)
  );

  assign gen_bit = in_payload ? lfsr_bit
                              : msb_first_bit(in_a2 ? A2_BYTE : A1_BYTE, frame_pos[2:0]);

  sbg_lane_skew #(.LANES(LANES)) u_skew (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (test_en),
    .in_bit(gen_bit),
    .lanes (lane_bit),
    .valid (lane_valid)
  );
endmodule

// File: rtl/sonet_bist_gen_chk.sv
module sonet_bist_gen_chk #(
  parameter int         LANES   = 4,
  parameter int         POS_W   = 17,
  parameter logic [7:0] A1_BYTE = 8'hF6,
  parameter logic [6:0] SEED    = 7'h7F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_en,
  input logic [LANES-1:0] lane_bit,
  input logic             lane_valid,
  input logic [POS_W-1:0] frame_pos,
  input logic             frame_wrap,
  input logic [6:0]       lfsr_q,
  input logic             lfsr_adv
);
  // R8: a disabled clock leaves every lane and the strobe clear
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> (lane_bit == '0) && !lane_valid);

  // R7: once valid, stays valid while enabled
  a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid && test_en) |=> lane_valid);

  // R5: wrap returns to the first frame bit
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (frame_pos == '0));

  // R2: frame bit 0 shows the MSB of the first alignment byte on lane 0
  a_r2_frame_head: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && frame_pos == '0) |=> (lane_bit[0] == A1_BYTE[7]));

  // R4: generator frozen outside payload, always moving inside it
  a_r4_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lfsr_adv |=> $stable(lfsr_q));
  a_r4_lfsr_move: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_adv |=> (lfsr_q != $past(lfsr_q)));

  // R3: the generator never falls into the all-zero lock-up state
  a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 7'd0);

  // R9: leaving reset starts at frame bit 0 with the seed loaded
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (frame_pos == '0) && (lfsr_q == SEED));

  // R6: each lane copies its lower neighbour on an enabled clock
  for (genvar k = 1; k < LANES; k++) begin : g_skew
    a_r6_lane_lag: assert property (@(posedge clk) disable iff (!rst_n)
      $past(test_en) |-> (lane_bit[k] == $past(lane_bit[k-1])));
  end
endmodule

bind sonet_bist_gen sonet_bist_gen_chk #(
  .LANES  (LANES),
  .POS_W  (POS_W),
  .A1_BYTE(A1_BYTE),
  .SEED   (SEED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_en   (test_en),
  .lane_bit  (lane_bit),
  .lane_valid(lane_valid),
  .frame_pos (frame_pos),
  .frame_wrap(frame_wrap),
  .lfsr_q    (lfsr_q),
  .lfsr_adv  (lfsr_adv)
);

// File: tb/sonet_bist_gen_tb.sv
`timescale 1ns/1ps
module sonet_bist_gen_tb;
  localparam int LANES = 4;
  localparam int FB    = 30;          // reduced frame: 24 preamble + 6 payload bytes
  localparam int FBITS = FB * 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             test_en = 1'b0;
  logic [LANES-1:0] lane_bit;
  logic             lane_valid;

  always #4 clk = ~clk;

  sonet_bist_gen #(.LANES(LANES), .FRAME_BYTES(FB)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en),
    .lane_bit(lane_bit), .lane_valid(lane_valid)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Reference model built from the requirements.
  int               m_pos = 0;
  logic [6:0]       m_lfsr = 7'h7F;
  logic [LANES-1:0] m_hist = '0;
  int               m_fill = 0;

  function automatic logic ref_bit(input int pos, input logic [6:0] l);
    if (pos < 96)  return 1'((8'hF6 >> (7 - pos % 8)) & 8'h01);
    if (pos < 192) return 1'((8'h28 >> (7 - pos % 8)) & 8'h01);
    return l[6];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic e);
    @(negedge clk);
    rst_n = r;
    test_en = e;
    @(posedge clk);
    #1;
    if (!r) begin
      m_pos = 0; m_lfsr = 7'h7F; m_hist = '0; m_fill = 0;
    end else if (!e) begin
      m_hist = '0; m_fill = 0;
    end else begin
      m_hist = {m_hist[LANES-2:0], ref_bit(m_pos, m_lfsr)};
      if (m_pos >= 192) m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
      m_pos = (m_pos + 1) % FBITS;
      if (m_fill < LANES) m_fill++;
    end
    check("R6 lanes", 32'(lane_bit), 32'(m_hist));
    check("R7 valid", 32'(lane_valid), 32'(m_fill == LANES));
  endtask

  task automatic grab_byte(output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b1);
      b = {b[6:0], lane_bit[0]};
    end
  endtask

  localparam int NSEG = 6;
  localparam int SEG_RST [NSEG] = '{0, 1, 1, 1, 0, 1};
  localparam int SEG_EN  [NSEG] = '{0, 1, 0, 1, 1, 1};
  localparam int SEG_LEN [NSEG] = '{3, 300, 5, 260, 2, 150};

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    // Table walk: R5 R4 R8 R9 through long segments across several frames
    for (int s = 0; s < NSEG; s++)
      for (int c = 0; c < SEG_LEN[s]; c++)
        step(1'(SEG_RST[s]), 1'(SEG_EN[s]));

    // R1: reset state
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    check("R1 reset lanes", 32'(lane_bit), 32'd0);
    check("R1 reset valid", 32'(lane_valid), 32'd0);

    // R2: preamble bytes, MSB first
    grab_byte(b); check("R2 first A1", 32'(b), 32'hF6);
    for (int i = 1; i < 11; i++) grab_byte(b);
    grab_byte(b); check("R2 last A1", 32'(b), 32'hF6);
    grab_byte(b); check("R2 first A2", 32'(b), 32'h28);
    for (int i = 13; i < 24; i++) grab_byte(b);
    check("R2 last A2", 32'(b), 32'h28);

    // R3: first payload byte from the all-ones seed
    grab_byte(b); check("R3 first payload", 32'(b), 32'hFE);

    // R8: pause mid payload, then resume
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R8 paused lanes", 32'(lane_bit), 32'd0);
    check("R8 paused valid", 32'(lane_valid), 32'd0);
    for (int i = 0; i < LANES - 1; i++) step(1'b1, 1'b1);
    check("R7 not yet valid", 32'(lane_valid), 32'd0);
    step(1'b1, 1'b1);
    check("R7 valid after fill", 32'(lane_valid), 32'd1);
    for (int i = 0; i < 32 - LANES; i++) step(1'b1, 1'b1);  // rest of payload bytes 1..4

    // R5: frame wraps back to A1
    grab_byte(b);            // payload byte 5, the last
    grab_byte(b); check("R5 wrap to A1", 32'(b), 32'hF6);
    for (int i = 1; i < 24; i++) grab_byte(b);

    // R4: second frame payload continues the sequence, not the seed
    grab_byte(b); check("R4 payload carried", 32'(b != 8'hFE), 32'd1);

    // R9: reset mid-frame restarts at A1 and the seed
    for (int i = 0; i < 13; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    grab_byte(b); check("R9 restart A1", 32'(b), 32'hF6);
    for (int i = 1; i < 24; i++) grab_byte(b);
    grab_byte(b); check("R9 restart seed", 32'(b), 32'hFE);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule